// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side front end of a serial nonvolatile memory holding a 16K x 8 array. Every pin of the serial link (bus clock, select, data in and the pause request) is brought into a fast system clock domain through two-flop synchronisers. The engine detects bus clock edges there, assembles bytes most significant bit first and decodes an 8-bit command. It then either streams array or status data back out, or passes write bytes and status writes on to a separate page-write sequencer and protection checker.

Reads go through a synchronous RAM port: one request yields the data a cycle later. The address advances after every byte and wraps from the top of the array to zero. Write bytes go out as single-cycle strobes, each with its address. That address steps only within a 32-byte page. The serial output is modelled as a data bit plus an output enable, which is low whenever the output would float.

A pause request suspends the transfer without losing its place. While the external write cycle is busy, only the status read is accepted. An unknown command makes the engine deaf until it is deselected and selected again.

Top module: `spimem_cmd_engine`

## Requirements
- R1: The bus may idle low (mode 0) or high (mode 3) while deselected. Input is sampled on rising bus clock edges and output changes on falling edges, with the same data in both modes.
- R2: Command, address and data bytes travel most significant bit first. Two address bytes follow a read or write command. Their top two bits are ignored and the low 14 bits select the byte.
- R3: A command byte with upper nibble 0000 is decoded on its low three bits, and bit 3 is ignored. 110 pulses `we_set`, 100 pulses `we_clr`, 101 is status read, 001 is status write, 011 is array read and 010 is array write. At most one handoff strobe is active in any cycle.
- R4: Any other command byte, including one with a nonzero upper nibble, causes no strobe and no array read, and keeps the output enable low until the engine is deselected and selected again.
- R5: During an array read, data in is ignored after the address. The byte at the address is driven first, then the address increments and wraps from 0x3FFF to 0x0000.
- R6: During an array write, each complete data byte pulses `wr_vld` with its address and data. Only the low 5 address bits increment, so the address rolls over within its 32-byte page.
- R7: A status write pulses `sr_wr_vld` once, carrying the first complete data byte. A status read repeatedly returns `status_byte`.
- R8: Pulling `pause_n` low while the bus clock is low pauses the transfer. Raising it while the clock is low resumes. While paused, the output enable is low and clock edges and data in are ignored, and the transfer resumes at the bit where it stopped.
- R9: While `wip` is high at the end of the command byte, every command except status read is ignored: no strobe, no array read and no output.
- R10: While deselected, the output enable is low and bus clock and data-in activity has no effect.
- R11: Deselecting on a byte boundary pulses `frame_end` once. Deselecting in the middle of a byte aborts the transfer: the partial byte causes no strobe and `frame_end` stays low.
- R12: After reset the output enable and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial bus clock (asynchronous) |
| spi_sel_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| pause_n | input | 1 | Active-low pause request |
| wip | input | 1 | External write cycle busy |
| status_byte | input | 8 | Status value returned by status read |
| mem_rd_en | output | 1 | Array read request |
| mem_addr | output | 14 | Array read address |
| mem_rd_data | input | 8 | Array read data, valid one cycle after the request |
| spi_miso_d | output | 1 | Serial output data bit |
| spi_miso_oe | output | 1 | Serial output enable |
| we_set | output | 1 | Strobe: set write enable |
| we_clr | output | 1 | Strobe: clear write enable |
| wr_vld | output | 1 | Strobe: write byte ready |
| wr_addr | output | 14 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| sr_wr_vld | output | 1 | Strobe: status write byte ready |
| sr_wr_data | output | 8 | Status write byte |
| frame_end | output | 1 | Clean deselect on a byte boundary |

## Verification
A change on any serial pin reaches the decoder two system clocks later, and a registered result follows on the third edge. A falling bus clock edge therefore updates `spi_miso_d` three clocks later, and a pause changes `spi_miso_oe` four clocks later. The bench holds every bus clock half for four system clocks. It reads the output just before it raises the clock, and it checks the output enable only after waiting two half periods, so every sample falls after the result has settled. Strobes are counted on every clock edge and compared once the transfer that should raise them has been closed.

// File: rtl/spimem_pkg.sv
`timescale 1ns/1ps
package spimem_pkg;
    localparam int ARRAY_AW = 14;
    localparam int PAGE_AW  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_RSR, ST_WDAT, ST_WSR, ST_IGN
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_SETWE, OP_CLRWE, OP_RDST, OP_WRST, OP_RDARR, OP_WRARR, OP_NONE
    } opcode_e;

    // Upper nibble must be zero; bit 3 is ignored.
    function automatic opcode_e decode_op(input logic [7:0] b);
        opcode_e r;
        r = OP_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b110:  r = OP_SETWE;
                3'b100:  r = OP_CLRWE;
                3'b101:  r = OP_RDST;
                3'b001:  r = OP_WRST;
                3'b011:  r = OP_RDARR;
                3'b010:  r = OP_WRARR;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/spimem_sync.sv
`timescale 1ns/1ps
module spimem_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spimem_hold.sv
`timescale 1ns/1ps
module spimem_hold (
    input  logic clk,
    input  logic rst,
    input  logic desel,
    input  logic clk_lvl,
    input  logic pause_n_lvl,
    output logic paused
);
    always_ff @(posedge clk) begin
        if (rst)           paused <= 1'b0;
        else if (desel)    paused <= 1'b0;
        else if (!clk_lvl) paused <= !pause_n_lvl;
    end

    // R8
    hold_change_chk: assert property (@(posedge clk) disable iff (rst)
        (paused != $past(paused)) |-> ($past(desel) || !$past(clk_lvl)));
endmodule

// File: rtl/spimem_txsr.sv
`timescale 1ns/1ps
module spimem_txsr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    output logic          bit_out
);
    logic [DW-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            bit_out <= sr[DW-1];
            sr      <= {sr[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spimem_cmd_engine.sv
`timescale 1ns/1ps
module spimem_cmd_engine
    import spimem_pkg::*;
#(
    parameter int AW = ARRAY_AW,
    parameter int PW = PAGE_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          spi_clk,
    input  logic          spi_sel_n,
    input  logic          spi_mosi,
    input  logic          pause_n,
    input  logic          wip,
    input  logic [7:0]    status_byte,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          spi_miso_d,
    output logic          spi_miso_oe,
    output logic          we_set,
    output logic          we_clr,
    output logic          wr_vld,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sr_wr_vld,
    output logic [7:0]    sr_wr_data,
    output logic          frame_end
);
    localparam int HI_W = AW - 8;

    logic [3:0] pins_s;
    logic s_clk, s_desel, s_mosi, s_pause_n, clk_prev, paused;
    logic sck_rise_q, sck_fall_q, byte_done, tx_load, rd_vld, sr_load;
    logic [6:0] rx_sr;
    logic [7:0] rx_byte, tx_val;
    logic [2:0] bit_cnt;
    logic [HI_W-1:0] addr_hi;
    logic [AW-1:0] addr;
    logic addr_phase, is_read;
    eng_state_e state;
    opcode_e op;

    spimem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
        .clk(clk), .rst(rst),
        .d({pause_n, spi_mosi, spi_sel_n, spi_clk}),
        .q(pins_s)
    );
    assign {s_pause_n, s_mosi, s_desel, s_clk} = pins_s;

    spimem_hold u_hold (
        .clk(clk), .rst(rst), .desel(s_desel),
        .clk_lvl(s_clk), .pause_n_lvl(s_pause_n), .paused(paused)
    );

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= s_clk;
    end

    always_comb begin
        sck_rise_q = s_clk && !clk_prev && !paused && !s_desel;
        sck_fall_q = !s_clk && clk_prev && !paused && !s_desel;
        rx_byte    = {rx_sr, s_mosi};
        byte_done  = sck_rise_q && (bit_cnt == 3'd7);
        op         = decode_op(rx_byte);
        tx_load    = sr_load || rd_vld;
        tx_val     = sr_load ? status_byte : mem_rd_data;
    end

    spimem_txsr #(.DW(8)) u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .load_val(tx_val),
        .shift(sck_fall_q), .bit_out(spi_miso_d)
    );

    assign mem_addr = addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;   bit_cnt <= '0;    rx_sr <= '0;
            addr_hi <= '0;      addr <= '0;       addr_phase <= 1'b0;
            is_read <= 1'b0;    spi_miso_oe <= 1'b0;
            rd_vld <= 1'b0;     sr_load <= 1'b0;  mem_rd_en <= 1'b0;
            we_set <= 1'b0;     we_clr <= 1'b0;   wr_vld <= 1'b0;
            sr_wr_vld <= 1'b0;  frame_end <= 1'b0;
            wr_addr <= '0;      wr_data <= '0;    sr_wr_data <= '0;
        end else begin
            we_set <= 1'b0;  we_clr <= 1'b0;  wr_vld <= 1'b0;
            sr_wr_vld <= 1'b0;  mem_rd_en <= 1'b0;  frame_end <= 1'b0;
            sr_load <= 1'b0;
            rd_vld <= mem_rd_en;
            spi_miso_oe <= !s_desel && !paused &&
                           (state == ST_RDAT || state == ST_RSR);
            if (s_desel) begin
                frame_end <= (state != ST_IDLE) && (bit_cnt == 3'd0);
                state     <= ST_IDLE;
                bit_cnt   <= '0;
            end else if (state == ST_IDLE) begin
                state      <= ST_OPC;
                bit_cnt    <= '0;
                addr_phase <= 1'b0;
            end else if (sck_rise_q) begin
                rx_sr   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done) begin
                    case (state)
                        ST_OPC: begin
                            if (wip && op != OP_RDST) state <= ST_IGN;
                            else begin
                                case (op)
                                    OP_SETWE: begin we_set <= 1'b1; state <= ST_IGN; end
                                    OP_CLRWE: begin we_clr <= 1'b1; state <= ST_IGN; end
                                    OP_RDST:  begin sr_load <= 1'b1; state <= ST_RSR; end
                                    OP_WRST:  state <= ST_WSR;
                                    OP_RDARR: begin is_read <= 1'b1; state <= ST_ADDR; end
                                    OP_WRARR: begin is_read <= 1'b0; state <= ST_ADDR; end
                                    default:  state <= ST_IGN;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (!addr_phase) begin
                                addr_hi    <= rx_byte[HI_W-1:0];
                                addr_phase <= 1'b1;
                            end else begin
                                addr <= {addr_hi, rx_byte};
                                if (is_read) begin
                                    mem_rd_en <= 1'b1;
                                    state     <= ST_RDAT;
                                end else begin
                                    state <= ST_WDAT;
                                end
                            end
                        end
                        ST_RDAT: begin
                            addr      <= addr + AW'(1);
                            mem_rd_en <= 1'b1;
                        end
                        ST_WDAT: begin
                            wr_vld  <= 1'b1;
                            wr_addr <= addr;
                            wr_data <= rx_byte;
                            addr    <= {addr[AW-1:PW], PW'(addr[PW-1:0] + PW'(1))};
                        end
                        ST_WSR: begin
                            sr_wr_vld  <= 1'b1;
                            sr_wr_data <= rx_byte;
                            state      <= ST_IGN;
                        end
                        ST_RSR:  sr_load <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R10
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (s_desel && $past(s_desel)) |-> !spi_miso_oe);

    // R8
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> !spi_miso_oe);

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_set, we_clr, wr_vld, sr_wr_vld, mem_rd_en, frame_end}));

    // R9
    busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPC && byte_done && wip && op != OP_RDST) |=> (state == ST_IGN));
endmodule

// File: tb/spimem_cmd_engine_tb.sv
`timescale 1ns/1ps
module spimem_cmd_engine_tb_top;
    localparam int H = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic spi_clk = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0, pause_n = 1'b1, wip = 1'b0;
    logic [7:0] status_byte = 8'h8C;
    logic mem_rd_en, spi_miso_d, spi_miso_oe, we_set, we_clr, wr_vld, sr_wr_vld, frame_end;
    logic [13:0] mem_addr, wr_addr;
    logic [7:0] mem_rd_data = 8'h00, wr_data, sr_wr_data;

    int nchk = 0, nerr = 0;
    bit done = 0;
    int n_set = 0, n_clr = 0, n_wr = 0, n_sr = 0, n_rd = 0, n_fe = 0, n_oe = 0;
    logic [13:0] wa [16];
    logic [7:0] wd [16];
    logic [7:0] sr_last = 8'h00;

    always #10 clk = ~clk;

    spimem_cmd_engine dut_i (
        .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
        .spi_mosi(spi_mosi), .pause_n(pause_n), .wip(wip), .status_byte(status_byte),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .spi_miso_d(spi_miso_d), .spi_miso_oe(spi_miso_oe), .we_set(we_set),
        .we_clr(we_clr), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .sr_wr_vld(sr_wr_vld), .sr_wr_data(sr_wr_data), .frame_end(frame_end)
    );

    function automatic logic [7:0] mem_f(input logic [13:0] a);
        return 8'(a[7:0] + 8'(a[13:8]) * 8'd37 + 8'd5);
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem_f(mem_addr);
            n_rd <= n_rd + 1;
        end
        if (we_set) n_set <= n_set + 1;
        if (we_clr) n_clr <= n_clr + 1;
        if (sr_wr_vld) begin n_sr <= n_sr + 1; sr_last <= sr_wr_data; end
        if (frame_end) n_fe <= n_fe + 1;
        if (spi_miso_oe) n_oe <= n_oe + 1;
        if (wr_vld) begin
            wa[n_wr % 16] <= wr_addr;
            wd[n_wr % 16] <= wr_data;
            n_wr <= n_wr + 1;
        end
    end

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame_open(input bit m3);
        spi_clk = m3;
        tick(H);
        spi_sel_n = 1'b0;
        tick(2 * H);
    endtask

    task automatic frame_close(input bit m3);
        if (!m3) spi_clk = 1'b0;
        tick(H);
        spi_sel_n = 1'b1;
        tick(3 * H);
    endtask

    // hold_at: bit index at which a pause is inserted, -1 for none
    task automatic xfer(input logic [7:0] tb, input int hold_at, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            spi_clk = 1'b0;
            if (i == hold_at) begin
                tick(H);
                pause_n = 1'b0;
                tick(2 * H);
                chk(spi_miso_oe == 1'b0, "R8 oe during pause", spi_miso_oe, 0);
                repeat (2) begin
                    spi_mosi = ~spi_mosi;
                    spi_clk = 1'b1; tick(H);
                    spi_clk = 1'b0; tick(H);
                end
                pause_n = 1'b1;
                tick(2 * H);
            end
            spi_mosi = tb[i];
            tick(H);
            rb[i] = spi_miso_d;
            spi_clk = 1'b1;
            tick(H);
        end
    endtask

    function automatic int exp_kind(input logic [7:0] b);
        // 0 setwe, 1 clrwe, 2 rdst, 3 wrst, 4 rdarr, 5 wrarr, 6 none
        if (b[7:4] != 4'h0) return 6;
        case (b[2:0])
            3'b110: return 0;
            3'b100: return 1;
            3'b101: return 2;
            3'b001: return 3;
            3'b011: return 4;
            3'b010: return 5;
            default: return 6;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        int s_set, s_clr, s_wr, s_sr, s_rd, s_fe, s_oe;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R12 reset state
        chk(spi_miso_oe == 0 && wr_vld == 0 && we_set == 0 && frame_end == 0,
            "R12 reset outputs", {spi_miso_oe, wr_vld, we_set, frame_end}, 0);

        // R10 activity while deselected
        s_oe = n_oe; s_rd = n_rd; s_fe = n_fe;
        for (int i = 0; i < 24; i++) begin
            spi_mosi = (i % 3 == 0);
            spi_clk = 1'b1; tick(H);
            spi_clk = 1'b0; tick(H);
        end
        chk(n_oe == s_oe && n_rd == s_rd && n_fe == s_fe, "R10 deselected activity",
            n_oe - s_oe + n_rd - s_rd + n_fe - s_fe, 0);

        // R3 R4 R7 R1 sweep of every command byte
        for (int op = 0; op < 256; op++) begin
            bit m3;
            int k;
            m3 = op[4];
            k = exp_kind(8'(op));
            s_set = n_set; s_clr = n_clr; s_sr = n_sr; s_rd = n_rd; s_fe = n_fe; s_oe = n_oe;
            frame_open(m3);
            xfer(8'(op), -1, rb);
            xfer(~8'(op), -1, rb);
            frame_close(m3);
            case (k)
                0: chk(n_set == s_set + 1 && n_clr == s_clr && n_oe == s_oe, "R3 set-enable strobe", n_set - s_set, 1);
                1: chk(n_clr == s_clr + 1 && n_set == s_set && n_oe == s_oe, "R3 clear-enable strobe", n_clr - s_clr, 1);
                2: chk(rb == status_byte && n_oe != s_oe, "R7 status read", rb, status_byte);
                3: chk(n_sr == s_sr + 1 && sr_last == ~8'(op), "R7 status write data", sr_last, ~8'(op));
                4, 5: chk(n_rd == s_rd && n_oe == s_oe && n_sr == s_sr, "R3 partial address no action", n_rd - s_rd, 0);
                default: chk(n_set == s_set && n_clr == s_clr && n_sr == s_sr && n_rd == s_rd && n_oe == s_oe,
                             "R4 invalid command silent", n_oe - s_oe + n_rd - s_rd, 0);
            endcase
            chk(n_fe == s_fe + 1, "R11 clean deselect strobe", n_fe - s_fe, 1);
        end

        // R4 invalid command followed by a read pattern
        s_rd = n_rd; s_oe = n_oe;
        frame_open(1'b0);
        xfer(8'h07, -1, rb); xfer(8'h03, -1, rb); xfer(8'h00, -1, rb);
        xfer(8'h10, -1, rb); xfer(8'h00, -1, rb);
        frame_close(1'b0);
        chk(n_rd == s_rd && n_oe == s_oe, "R4 no output after invalid", n_oe - s_oe, 0);

        // R5 R2 R1 read, mode 0, don't-care address bits set
        frame_open(1'b0);
        xfer(8'h03, -1, rb); xfer(8'hC1, -1, rb); xfer(8'h23, -1, rb);
        for (int k = 0; k < 3; k++) begin
            xfer(8'hA5, -1, rb);
            chk(rb == mem_f(14'h0123 + 14'(k)), "R5 mode0 read byte", rb, mem_f(14'h0123 + 14'(k)));
        end
        frame_close(1'b0);

        // R5 R1 read wrap, mode 3
        frame_open(1'b1);
        xfer(8'h0B, -1, rb); xfer(8'h3F, -1, rb); xfer(8'hFE, -1, rb);
        for (int k = 0; k < 4; k++) begin
            logic [13:0] ea;
            ea = 14'h3FFE + 14'(k);
            xfer(8'h5A ^ 8'(k), -1, rb);
            chk(rb == mem_f(ea), "R5 mode3 read wrap", rb, mem_f(ea));
        end
        frame_close(1'b1);

        // R8 pause in the middle of a read byte
        frame_open(1'b0);
        xfer(8'h03, -1, rb); xfer(8'h02, -1, rb); xfer(8'h40, -1, rb);
        xfer(8'h00, 4, rb);
        chk(rb == mem_f(14'h0240), "R8 read across pause", rb, mem_f(14'h0240));
        xfer(8'h00, -1, rb);
        chk(rb == mem_f(14'h0241), "R8 read after pause", rb, mem_f(14'h0241));
        frame_close(1'b0);

        // R6 page rollover of write address
        frame_open(1'b0); xfer(8'h06, -1, rb); frame_close(1'b0);
        s_wr = n_wr;
        frame_open(1'b0);
        xfer(8'h02, -1, rb); xfer(8'h40, -1, rb); xfer(8'h1E, -1, rb);
        for (int k = 0; k < 4; k++) xfer(8'h11 * 8'(k + 1), -1, rb);
        frame_close(1'b0);
        chk(n_wr == s_wr + 4, "R6 write strobe count", n_wr - s_wr, 4);
        for (int k = 0; k < 4; k++) begin
            logic [13:0] ea;
            ea = {9'h000, 5'(5'h1E + 5'(k))};
            chk(wa[(s_wr + k) % 16] == ea && wd[(s_wr + k) % 16] == 8'h11 * 8'(k + 1),
                "R6 write address in page", wa[(s_wr + k) % 16], ea);
        end

        // R11 abort in the middle of a byte
        s_wr = n_wr; s_fe = n_fe;
        frame_open(1'b0);
        xfer(8'h02, -1, rb); xfer(8'h00, -1, rb); xfer(8'h40, -1, rb);
        xfer(8'h5A, -1, rb);
        for (int i = 7; i >= 4; i--) begin
            spi_clk = 1'b0; spi_mosi = i[0]; tick(H);
            spi_clk = 1'b1; tick(H);
        end
        frame_close(1'b0);
        chk(n_wr == s_wr + 1 && wa[s_wr % 16] == 14'h0040 && wd[s_wr % 16] == 8'h5A,
            "R11 only complete byte handed off", n_wr - s_wr, 1);
        chk(n_fe == s_fe, "R11 no frame end on abort", n_fe - s_fe, 0);

        // R9 busy filtering
        wip = 1'b1;
        s_rd = n_rd; s_oe = n_oe; s_set = n_set;
        frame_open(1'b0);
        xfer(8'h03, -1, rb); xfer(8'h00, -1, rb); xfer(8'h10, -1, rb); xfer(8'h00, -1, rb);
        frame_close(1'b0);
        frame_open(1'b1); xfer(8'h06, -1, rb); frame_close(1'b1);
        chk(n_rd == s_rd && n_oe == s_oe && n_set == s_set, "R9 busy ignores commands",
            n_rd - s_rd + n_oe - s_oe + n_set - s_set, 0);
        status_byte = 8'hF3;
        frame_open(1'b0);
        xfer(8'h05, -1, rb); xfer(8'h00, -1, rb);
        chk(rb == 8'hF3, "R9 status read while busy", rb, 8'hF3);
        xfer(8'h00, -1, rb);
        chk(rb == 8'hF3, "R7 repeated status read", rb, 8'hF3);
        frame_close(1'b0);
        wip = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule